// File: doc/BRIEF.md
# Segmented Dependency-Matrix Wake-Up Unit

This unit tracks, for each entry of an out-of-order issue window, which older producers it still waits on, and raises a per-entry ready flag once all of them have issued. It does not keep a full window-wide dependency matrix. The window is cut into 16-entry segments, and each consumer row holds 32 dependency columns. Columns 0 to 15 stand for the segment just before the consumer's own segment, taken circularly, so segment 0 looks back to the last segment. Columns 16 to 31 stand for the consumer's own segment. The storage grows linearly with the window size, and a row's wake-up logic only ever looks at two segments of grants.

A dispatch names the consumer entry and up to `NUM_SRC` producer entries. A named producer is still pending when it is valid, has not issued, and is not being granted in the same cycle. A pending producer inside the two-segment reach sets one column in the consumer's row. A pending producer beyond the reach holds the dispatch back with a combinational stall until that producer issues. The issue-grant vector clears the matching column in every row that covers the granted entry, and it also marks the granted entry as issued. A flush empties the whole unit. Selection and retirement sit outside this block.

Top module: `wk_seg_matrix`

## Requirements
- R1: After reset, `ready` is all zero and `disp_stall` is low.
- R2: A dispatch with no pending producers makes the consumer's `ready` bit go high at the next clock edge.
- R3: A pending producer in the consumer's own segment (same `idx[IDX_W-1:4]`) keeps the consumer not ready until that producer is granted. The consumer becomes ready at the edge that takes the grant, if nothing else is pending.
- R4: A pending producer in the previous segment (consumer segment minus one, modulo the segment count, so segment 0 wraps to the last segment) is tracked in the same way as a same-segment producer.
- R5: A dispatch naming a pending producer outside the two-segment reach drives `disp_stall` high in the same cycle, and the consumer entry is not written.
- R6: A producer outside the reach that has already issued, or is not valid, neither stalls nor delays the consumer.
- R7: With two pending producers, the consumer becomes ready only after both have been granted.
- R8: A producer granted in the same cycle as the consumer's dispatch creates no dependence.
- R9: A granted entry's `ready` bit goes low at the next edge and stays low until the entry is dispatched again.
- R10: `flush` clears every row and valid flag at the next edge and takes priority over a dispatch in the same cycle. Entries invalidated by it never stall or delay a later dispatch.
- R11: A dispatch into an occupied entry replaces its old dependency bits entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears all entries |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_idx | input | IDX_W | Consumer entry being written |
| src_valid | input | NUM_SRC | Per-source valid flag |
| src_idx | input | NUM_SRC x IDX_W | Producer entry per source |
| issue_grant | input | WIN | Entries issued this cycle |
| ready | output | WIN | Entry valid, not issued, no dependences left |
| disp_stall | output | 1 | Dispatch held: pending producer out of reach |

## Verification
The wake-up path is driven with producers in the consumer's own segment, in the previous segment, and across the wrap from segment 0 to the last segment. This separates correct column placement from a wrong or missing back-segment mapping. Out-of-reach producers are applied both while pending and after issue, which checks that the stall depends on producer state and not only on distance. Two-source consumers, a grant in the same cycle as the dispatch, re-dispatch into a waiting entry, and flush combined with dispatch each target a separate ordering rule.

// File: rtl/wk_pkg.sv
package wk_pkg;

    localparam int SEG_SIZE = 16;
    localparam int OFF_W    = 4;
    localparam int ROW_W    = 2 * SEG_SIZE;
    localparam int COL_W    = 5;

    typedef logic [ROW_W-1:0] dep_row_t;

    typedef enum logic [1:0] {
        REL_NONE = 2'd0,
        REL_PREV = 2'd1,
        REL_SAME = 2'd2,
        REL_FAR  = 2'd3
    } src_rel_e;

    typedef struct packed {
        logic valid;
        logic issued;
    } ent_state_t;

    // Column of a producer in a consumer row: own segment sits in the upper half.
    function automatic logic [COL_W-1:0] col_of(src_rel_e rel, logic [OFF_W-1:0] off);
        return {rel == REL_SAME, off};
    endfunction

    function automatic dep_row_t col_mask(src_rel_e rel, logic [OFF_W-1:0] off);
        dep_row_t m;
        m = '0;
        if (rel == REL_SAME || rel == REL_PREV)
            m[col_of(rel, off)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/wk_dep_row.sv
module wk_dep_row
    import wk_pkg::*;
#(
    parameter int WIN   = 128,
    parameter int ENTRY = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           flush,
    input  logic           wr_en,
    input  dep_row_t       wr_bits,
    input  logic [WIN-1:0] grant,
    output logic           ready,
    output logic           pending
);
    localparam int NSEG   = WIN / SEG_SIZE;
    localparam int OWN    = ENTRY / SEG_SIZE;
    localparam int PREV   = (OWN + NSEG - 1) % NSEG;

    dep_row_t   bits_q;
    ent_state_t st_q;
    dep_row_t   clr;
    logic       self_gnt;

    assign clr      = {grant[OWN*SEG_SIZE +: SEG_SIZE], grant[PREV*SEG_SIZE +: SEG_SIZE]};
    assign self_gnt = grant[ENTRY];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            bits_q <= '0;
            st_q   <= '0;
        end else if (wr_en) begin
            bits_q    <= wr_bits;
            st_q.valid  <= 1'b1;
            st_q.issued <= 1'b0;
        end else begin
            bits_q <= bits_q & ~clr;
            if (self_gnt && st_q.valid)
                st_q.issued <= 1'b1;
        end
    end

    assign ready   = st_q.valid && !st_q.issued && (bits_q == '0);
    assign pending = st_q.valid && !st_q.issued && !self_gnt;

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!st_q.valid && bits_q == '0)); // R10

    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!flush && !wr_en && clr != '0) |=> ((bits_q & $past(clr)) == '0)); // R3

    AST_ISSUED_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (!flush && !wr_en && self_gnt) |=> !ready); // R9

endmodule

// File: rtl/wk_disp_check.sv
module wk_disp_check
    import wk_pkg::*;
#(
    parameter int WIN     = 128,
    parameter int NUM_SRC = 2,
    localparam int IDX_W  = $clog2(WIN)
) (
    input  logic                            disp_valid,
    input  logic [IDX_W-1:0]                disp_idx,
    input  logic [NUM_SRC-1:0]              src_valid,
    input  logic [NUM_SRC-1:0][IDX_W-1:0]   src_idx,
    input  logic [WIN-1:0]                  pending,
    output dep_row_t                        dep_bits,
    output logic                            stall
);
    localparam int SEGN_W = IDX_W - OFF_W;

    logic [SEGN_W-1:0] cseg;
    logic [SEGN_W-1:0] pseg;
    src_rel_e          rel [NUM_SRC];

    assign cseg = disp_idx[IDX_W-1:OFF_W];
    assign pseg = cseg - SEGN_W'(1);

    always_comb begin
        dep_bits = '0;
        stall    = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (!src_valid[s] || !pending[src_idx[s]])
                rel[s] = REL_NONE;
            else if (src_idx[s][IDX_W-1:OFF_W] == cseg)
                rel[s] = REL_SAME;
            else if (src_idx[s][IDX_W-1:OFF_W] == pseg)
                rel[s] = REL_PREV;
            else
                rel[s] = REL_FAR;
            dep_bits = dep_bits | col_mask(rel[s], src_idx[s][OFF_W-1:0]);
            if (rel[s] == REL_FAR && disp_valid)
                stall = 1'b1;
        end
    end

endmodule

// File: rtl/wk_seg_matrix.sv
module wk_seg_matrix
    import wk_pkg::*;
#(
    parameter int WIN     = 128,
    parameter int NUM_SRC = 2,
    localparam int IDX_W  = $clog2(WIN)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          disp_valid,
    input  logic [IDX_W-1:0]              disp_idx,
    input  logic [NUM_SRC-1:0]            src_valid,
    input  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx,
    input  logic [WIN-1:0]                issue_grant,
    output logic [WIN-1:0]                ready,
    output logic                          disp_stall
);
    logic [WIN-1:0] pending;
    logic [WIN-1:0] row_wr;
    dep_row_t       dep_bits;
    logic           accept;

    wk_disp_check #(.WIN(WIN), .NUM_SRC(NUM_SRC)) chk_i (
        .disp_valid (disp_valid),
        .disp_idx   (disp_idx),
        .src_valid  (src_valid),
        .src_idx    (src_idx),
        .pending    (pending),
        .dep_bits   (dep_bits),
        .stall      (disp_stall)
    );

    assign accept = disp_valid && !disp_stall && !flush;

    for (genvar e = 0; e < WIN; e++) begin : g_row
        assign row_wr[e] = accept && (disp_idx == IDX_W'(e));
        wk_dep_row #(.WIN(WIN), .ENTRY(e)) row_i (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .wr_en   (row_wr[e]),
            .wr_bits (dep_bits),
            .grant   (issue_grant),
            .ready   (ready[e]),
            .pending (pending[e])
        );
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_wr)); // R2

    AST_FRESH_READY: assert property (@(posedge clk) disable iff (rst)
        (accept && dep_bits == '0) |=> ready[$past(disp_idx)]); // R2

    AST_STALL_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
        disp_stall |-> (disp_valid && src_valid != '0)); // R5

    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        disp_stall |-> (row_wr == '0)); // R5

endmodule

// File: tb/wk_seg_matrix_tb.sv
module wk_seg_matrix_tb_top;
    localparam int WIN   = 128;
    localparam int NSRC  = 2;
    localparam int IDX_W = $clog2(WIN);

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       flush = 1'b0;
    logic                       disp_valid = 1'b0;
    logic [IDX_W-1:0]           disp_idx = '0;
    logic [NSRC-1:0]            src_valid = '0;
    logic [NSRC-1:0][IDX_W-1:0] src_idx = '0;
    logic [WIN-1:0]             issue_grant = '0;
    logic [WIN-1:0]             ready;
    logic                       disp_stall;

    int applied = 0;
    int errors  = 0;
    bit done    = 0;

    typedef struct {
        logic [WIN-1:0] rdy;
        string          tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    wk_seg_matrix #(.WIN(WIN), .NUM_SRC(NSRC)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .disp_valid(disp_valid), .disp_idx(disp_idx),
        .src_valid(src_valid), .src_idx(src_idx),
        .issue_grant(issue_grant), .ready(ready), .disp_stall(disp_stall)
    );

    function automatic logic [WIN-1:0] mk(int a = -1, int b = -1, int c = -1, int d = -1);
        logic [WIN-1:0] v = '0;
        if (a >= 0) v[a] = 1'b1;
        if (b >= 0) v[b] = 1'b1;
        if (c >= 0) v[c] = 1'b1;
        if (d >= 0) v[d] = 1'b1;
        return v;
    endfunction

    task automatic drive(input logic dv, input int di, input int s0, input int s1,
                         input logic [WIN-1:0] gnt, input logic fl,
                         input logic exp_stall, input logic [WIN-1:0] exp_rdy, input string tag);
        exp_t it;
        @(negedge clk);
        disp_valid   = dv;
        disp_idx     = IDX_W'(di);
        src_valid[0] = (s0 >= 0);
        src_idx[0]   = IDX_W'(s0 < 0 ? 0 : s0);
        src_valid[1] = (s1 >= 0);
        src_idx[1]   = IDX_W'(s1 < 0 ? 0 : s1);
        issue_grant  = gnt;
        flush        = fl;
        #1;
        applied++;
        if (disp_stall !== exp_stall) begin
            errors++;
            $display("FAIL %s stall: actual %b expected %b", tag, disp_stall, exp_stall);
        end
        it.rdy = exp_rdy;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                applied++;
                if (ready !== it.rdy) begin
                    errors++;
                    $display("FAIL %s ready: actual %h expected %h", it.tag, ready, it.rdy);
                end
            end
        end
    end

    initial begin : watchdog
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        applied++;
        if (ready !== '0 || disp_stall !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual %h/%b expected 0/0", ready, disp_stall);
        end
        drive(1,   5, -1, -1, '0, 0, 0, mk(5), "R2 plain dispatch");
        drive(1,  20,  5, -1, '0, 0, 0, mk(5), "R4 prev-seg dep");
        drive(1,   8,  5, -1, '0, 0, 0, mk(5), "R3 same-seg dep");
        drive(1,  40,  5, -1, '0, 0, 1, mk(5), "R5 far pending stall");
        drive(0,   0, -1, -1, mk(5), 0, 0, mk(20, 8), "R3 R4 R9 grant wakes");
        drive(1,  40,  5, -1, '0, 0, 0, mk(20, 8, 40), "R6 far issued");
        drive(1, 120, -1, -1, '0, 0, 0, mk(20, 8, 40, 120), "R2 last seg");
        drive(1,   3, 120, 8, '0, 0, 0, mk(20, 8, 40, 120), "R4 R7 wrap two deps");
        drive(0,   0, -1, -1, mk(120), 0, 0, mk(20, 8, 40), "R7 first of two");
        drive(0,   0, -1, -1, mk(8), 0, 0, mk(20, 40, 3), "R7 second of two");
        drive(1,  50, 40, -1, mk(40), 0, 0, mk(20, 3, 50), "R8 same-cycle grant");
        drive(1,  60, 20, -1, '0, 0, 1, mk(20, 3, 50), "R5 far stall again");
        drive(1,  21,  3, -1, '0, 0, 0, mk(20, 3, 50), "R11 waiting entry");
        drive(1,  21, -1, -1, '0, 0, 0, mk(20, 3, 50, 21), "R11 redispatch clears");
        drive(1,  70, -1, -1, '0, 1, 0, '0, "R10 flush beats dispatch");
        drive(1,  70, -1, -1, '0, 0, 0, mk(70), "R10 after flush");
        drive(1, 100,  5, -1, '0, 0, 0, mk(70, 100), "R10 flushed producer");
        drive(0,   0, -1, -1, '0, 0, 0, mk(70, 100), "R9 hold");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule